// File: doc/BRIEF.md
# Slotted Backoff Channel Access Engine

This block decides when a low-rate wireless MAC may start sending a frame on a shared channel. A transmit request starts an access attempt. The engine draws a random backoff count from a seeded linear feedback shift register. It counts that number down, one step per backoff-boundary strobe from the superframe timer, and then asks the radio for a clear channel assessment (CCA).

An idle channel leads to a transmit grant on the next backoff boundary. A busy channel widens the random window and starts a new backoff. The engine counts busy results, and once they pass a configured limit it gives up and reports failure. Grant and failure are single-cycle pulses, after which the engine waits for the next request. Frame transfer, acknowledgments and frame retries belong to other blocks.

Top module: `csma_slot_engine`

## Requirements
- R1: While rst_ni is low and directly after reset, cca_req_o, grant_o and fail_o are 0, the engine is idle, and the random register holds 16'hACE1.
- R2: A req_i pulse while idle starts an access with busy count 0 and exponent 3. It advances the random register by one step: the register shifts left and bit 0 takes s[15]^s[13]^s[12]^s[10]. The drawn count is the low exponent bits of the new register value.
- R3: The countdown moves only on cycles with bnd_i high. With a drawn count N, cca_req_o rises in the cycle after the (N+1)-th bnd_i strobe that follows the draw.
- R4: cca_req_o stays high until a cycle with cca_done_i high, and cca_busy_i is sampled only in that cycle. cca_done_i and cca_busy_i have no effect at any other time.
- R5: After an idle result, cca_req_o drops and the engine waits for the next bnd_i strobe. grant_o is then high for exactly the one cycle after that strobe, and the engine returns to idle.
- R6: A busy result that leaves the busy count at or below 4 drops cca_req_o. The exponent becomes min(exponent+1, 5), the register steps once, and a new count is drawn with the new exponent.
- R7: The busy result that takes the busy count above 4 (the fifth busy result of one access) makes fail_o high for exactly the cycle after that cca_done_i. The engine then returns to idle with no further CCA request.
- R8: seed_load_i high loads seed_i into the random register at the next edge. A zero seed is stored as 16'h0001.
- R9: req_i has no effect while an access is in progress: no new draw and no change in the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_load_i | input | 1 | Load seed_i into the random register |
| seed_i | input | 16 | Seed value |
| req_i | input | 1 | Transmit request pulse |
| bnd_i | input | 1 | Backoff-period boundary strobe |
| cca_done_i | input | 1 | Channel assessment result valid |
| cca_busy_i | input | 1 | Assessment result, 1 = busy |
| cca_req_o | output | 1 | Channel assessment request |
| grant_o | output | 1 | Transmit grant pulse |
| fail_o | output | 1 | Channel access failure pulse |

## Verification
The hardest outcome to reach from the ports is failure at the busy limit with the exponent held at its cap. It needs five busy results in a row, each after a full random countdown. The bench forces every result busy in directed runs and mixes in random results elsewhere. It predicts each drawn count by stepping its own register model, so every boundary strobe can be checked to the cycle. During countdowns and CCA waits it also injects stray requests and stray assessment results. Because the drawn counts must still match afterwards, any spurious redraw shows up.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BACKOFF,
    ST_CCA,
    ST_ALIGN,
    ST_GRANT,
    ST_FAIL
  } acc_state_e;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int unsigned           W    = 16,
  parameter logic [W-1:0]          TAPS = 16'hB400,
  parameter logic [W-1:0]          RST  = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] state_q;

  assign next_o = {state_q[W-2:0], ^(state_q & TAPS)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= RST;
    else if (load_i)  state_q <= (seed_i == '0) ? W'(1) : seed_i;
    else if (step_i)  state_q <= next_o;
  end
endmodule

// File: rtl/csma_backoff_cnt.sv
module csma_backoff_cnt #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (dec_i && !zero_o)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/csma_attempt.sv
module csma_attempt #(
  parameter int unsigned MIN_BE = 3,
  parameter int unsigned MAX_BE = 5,
  parameter int unsigned MAX_NB = 4,
  parameter int unsigned BE_W   = 3,
  parameter int unsigned NB_W   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            busy_i,
  output logic [BE_W-1:0] be_bump_o,
  output logic            limit_o
);
  logic [BE_W-1:0] be_q;
  logic [NB_W-1:0] nb_q;

  assign be_bump_o = (be_q < BE_W'(MAX_BE)) ? be_q + 1'b1 : be_q;
  // next busy result would exceed the limit
  assign limit_o   = (nb_q >= NB_W'(MAX_NB));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      be_q <= BE_W'(MIN_BE);
      nb_q <= '0;
    end else if (clear_i) begin
      be_q <= BE_W'(MIN_BE);
      nb_q <= '0;
    end else if (busy_i) begin
      be_q <= be_bump_o;
      nb_q <= nb_q + 1'b1;
    end
  end
endmodule

// File: rtl/csma_slot_engine.sv
module csma_slot_engine
  import csma_pkg::*;
#(
  parameter int unsigned            LFSR_W_P    = 16,
  parameter logic [LFSR_W_P-1:0]    LFSR_TAPS_P = 16'hB400,
  parameter logic [LFSR_W_P-1:0]    LFSR_RST_P  = 16'hACE1,
  parameter int unsigned            MIN_BE_P    = 3,
  parameter int unsigned            MAX_BE_P    = 5,
  parameter int unsigned            MAX_NB_P    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                seed_load_i,
  input  logic [LFSR_W_P-1:0] seed_i,
  input  logic                req_i,
  input  logic                bnd_i,
  input  logic                cca_done_i,
  input  logic                cca_busy_i,
  output logic                cca_req_o,
  output logic                grant_o,
  output logic                fail_o
);
  localparam int unsigned CW   = MAX_BE_P;
  localparam int unsigned BE_W = $clog2(MAX_BE_P + 2);
  localparam int unsigned NB_W = $clog2(MAX_NB_P + 2);

  acc_state_e state_q, state_d;

  logic                start, cca_hit, busy_hit, redraw, draw;
  logic                cnt_zero, limit;
  logic [BE_W-1:0]     be_bump, draw_be;
  logic [CW-1:0]       mask, draw_val;
  logic [LFSR_W_P-1:0] rnd_next;

  assign start    = (state_q == ST_IDLE) && req_i;
  assign cca_hit  = (state_q == ST_CCA) && cca_done_i;
  assign busy_hit = cca_hit && cca_busy_i;
  assign redraw   = busy_hit && !limit;
  assign draw     = start || redraw;
  assign draw_be  = start ? BE_W'(MIN_BE_P) : be_bump;

  always_comb begin
    for (int i = 0; i < int'(CW); i++) mask[i] = (i < int'(draw_be));
  end
  assign draw_val = rnd_next[CW-1:0] & mask;

  csma_lfsr #(
    .W    (LFSR_W_P),
    .TAPS (LFSR_TAPS_P),
    .RST  (LFSR_RST_P)
  ) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (seed_load_i),
    .seed_i (seed_i),
    .step_i (draw),
    .next_o (rnd_next)
  );

  csma_backoff_cnt #(.CW(CW)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (draw),
    .load_val_i (draw_val),
    .dec_i      ((state_q == ST_BACKOFF) && bnd_i),
    .zero_o     (cnt_zero)
  );

  csma_attempt #(
    .MIN_BE (MIN_BE_P),
    .MAX_BE (MAX_BE_P),
    .MAX_NB (MAX_NB_P),
    .BE_W   (BE_W),
    .NB_W   (NB_W)
  ) i_attempt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start),
    .busy_i    (busy_hit),
    .be_bump_o (be_bump),
    .limit_o   (limit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = ST_BACKOFF;
      ST_BACKOFF: if (bnd_i && cnt_zero) state_d = ST_CCA;
      ST_CCA:     if (cca_done_i) begin
                    if (!cca_busy_i) state_d = ST_ALIGN;
                    else if (limit)  state_d = ST_FAIL;
                    else             state_d = ST_BACKOFF;
                  end
      ST_ALIGN:   if (bnd_i) state_d = ST_GRANT;
      ST_GRANT,
      ST_FAIL:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign cca_req_o = (state_q == ST_CCA);
  assign grant_o   = (state_q == ST_GRANT);
  assign fail_o    = (state_q == ST_FAIL);
endmodule

// File: rtl/csma_slot_engine_chk.sv
module csma_slot_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bnd_i,
  input logic cca_done_i,
  input logic cca_busy_i,
  input logic cca_req_o,
  input logic grant_o,
  input logic fail_o
);
  // R3
  cca_bnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cca_req_o) |-> $past(bnd_i));
  // R4
  cca_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cca_req_o && !cca_done_i |=> cca_req_o);
  // R4
  cca_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cca_req_o && cca_done_i |=> !cca_req_o);
  // R5
  grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);
  // R5
  grant_bnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(bnd_i));
  // R7
  fail_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);
  // R7
  fail_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> $past(cca_req_o && cca_done_i && cca_busy_i));
endmodule

bind csma_slot_engine csma_slot_engine_chk i_chk (.*);

// File: tb/test_csma_slot_engine.sv
module test_csma_slot_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_BE = 3;
  localparam int MAX_BE = 5;
  localparam int MAX_NB = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        seed_load_i;
  logic [15:0] seed_i;
  logic        req_i, bnd_i, cca_done_i, cca_busy_i;
  logic        cca_req_o, grant_o, fail_o;

  csma_slot_engine i_csma_slot_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .seed_load_i (seed_load_i),
    .seed_i      (seed_i),
    .req_i       (req_i),
    .bnd_i       (bnd_i),
    .cca_done_i  (cca_done_i),
    .cca_busy_i  (cca_busy_i),
    .cca_req_o   (cca_req_o),
    .grant_o     (grant_o),
    .fail_o      (fail_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0;
  int bad = 0;
  logic [15:0] m_lfsr;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int draw_cnt(input logic [15:0] s, input int be);
    return int'(s) & ((1 << be) - 1);
  endfunction

  task automatic cyc(input bit r, input bit b, input bit d, input bit bz);
    @(negedge clk_i);
    req_i = r; bnd_i = b; cca_done_i = d; cca_busy_i = bz;
    @(posedge clk_i);
    #1;
    req_i = 0; bnd_i = 0; cca_done_i = 0; cca_busy_i = 0;
  endtask

  task automatic load_seed(input logic [15:0] s);
    @(negedge clk_i);
    seed_load_i = 1; seed_i = s;
    @(posedge clk_i);
    #1;
    seed_load_i = 0;
    m_lfsr = (s == 16'h0) ? 16'h0001 : s;
  endtask

  // mode 0: random results, 1: always busy, 2: always idle
  task automatic run_access(input int mode);
    int nb = 0;
    int be = MIN_BE;
    int cnt;
    bit busy;
    cyc(1, 0, 0, 0);
    m_lfsr = step(m_lfsr);
    cnt = draw_cnt(m_lfsr, be);
    chk(cca_req_o == 0 && grant_o == 0 && fail_o == 0, "R2 start", int'(cca_req_o), 0);
    forever begin
      for (int k = 0; k <= cnt; k++) begin
        repeat ($urandom % 3) begin
          cyc(bit'($urandom % 2), 0, bit'($urandom % 2), bit'($urandom % 2));
          chk(cca_req_o == 0, "R9/R4 noise in backoff", int'(cca_req_o), 0);
        end
        cyc(0, 1, 0, 0);
        chk(cca_req_o == (k == cnt), "R3 countdown", int'(cca_req_o), int'(k == cnt));
      end
      repeat ($urandom % 3) begin
        cyc(bit'($urandom % 2), 0, 0, bit'($urandom % 2));
        chk(cca_req_o == 1, "R4 hold", int'(cca_req_o), 1);
      end
      busy = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : bit'($urandom % 2);
      cyc(0, 0, 1, busy);
      if (!busy) begin
        chk(cca_req_o == 0 && grant_o == 0, "R5 idle result", int'(grant_o), 0);
        repeat ($urandom % 3) begin
          cyc(bit'($urandom % 2), 0, bit'($urandom % 2), 0);
          chk(grant_o == 0, "R5 wait boundary", int'(grant_o), 0);
        end
        cyc(0, 1, 0, 0);
        chk(grant_o == 1, "R5 grant", int'(grant_o), 1);
        cyc(0, 0, 0, 0);
        chk(grant_o == 0 && cca_req_o == 0, "R5 pulse end", int'(grant_o), 0);
        return;
      end
      nb++;
      if (nb > MAX_NB) begin
        chk(fail_o == 1, "R7 fail", int'(fail_o), 1);
        cyc(0, 0, 0, 0);
        chk(fail_o == 0 && cca_req_o == 0, "R7 pulse end", int'(fail_o), 0);
        return;
      end
      chk(fail_o == 0 && cca_req_o == 0, "R6 retry", int'(fail_o), 0);
      be = (be < MAX_BE) ? be + 1 : be;
      m_lfsr = step(m_lfsr);
      cnt = draw_cnt(m_lfsr, be);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog all requirements act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_ni = 0; seed_load_i = 0; seed_i = 0;
    req_i = 0; bnd_i = 0; cca_done_i = 0; cca_busy_i = 0;
    m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk_i);
    chk(cca_req_o == 0 && grant_o == 0 && fail_o == 0, "R1 reset", int'(cca_req_o | grant_o | fail_o), 0);
    rst_ni = 1;
    cyc(0, 1, 1, 1);
    chk(cca_req_o == 0 && grant_o == 0 && fail_o == 0, "R1/R4 idle ignores strobes", int'(cca_req_o | grant_o | fail_o), 0);
    // R1: first draw comes from the reset value
    run_access(2);
    // R6, R7: exponent reaches cap, then failure
    run_access(1);
    run_access(1);
    // R8: explicit seed and zero seed
    load_seed(16'h1234);
    run_access(0);
    load_seed(16'h0000);
    run_access(2);
    load_seed(16'hFFFF);
    run_access(1);
    for (int n = 0; n < 40; n++) begin
      if (($urandom % 8) == 0) load_seed(16'($urandom));
      run_access(int'($urandom % 4) % 3);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule